// File: doc/BRIEF.md
# Flash flag status register

This block keeps the flag byte of a serial NOR flash controller. The command decoder hands it one strobe per accepted opcode: program, optionally marked as an OTP program; erase; suspend; resume; status write; and flag clear. The program engine and the array decoder supply status levels: busy, operation done, VPP valid, lock-register hit, block-protect hit, OTP lock, the status write-disable bit, and the write-protect pin. The engine also supplies its failure and erase-suspend indications.

Error flags are sticky. They drop only on a clear-flags command. While an error flag is up, later commands of the class it guards are refused: `reject_o` rises in the same cycle, and no start or write pulse is issued. The register byte is always readable on `fsr_o`. Bit 7 is the ready indication, taken as the inverse of busy.

Top module: `flash_flag_status`

## Requirements
- R1: After reset, bits 6:0 of `fsr_o` are zero (with `erase_susp_i` low) and bit 7 equals the inverse of `busy_i`.
- R2: Bit 4 (program fail) sets on the cycle after `prog_fail_i` is high and stays set until a clear-flags command.
- R3: While bit 4 is set, a program command raises `reject_o` and gives no `prog_start_o`. An erase command is still accepted.
- R4: Bit 3 (VPP error) sets when a program or erase starts with `vpp_ok_i` low. It also sets when `vpp_ok_i` is low while an operation is running. An operation runs from its start until `op_done_i`. The bit stays set until cleared.
- R5: While bit 3 is set, program and erase commands are rejected. A status write is still accepted.
- R6: Bit 2 (program suspend) sets on the cycle after an accepted suspend command. It clears on the cycle after an accepted resume command.
- R7: Bit 1 (protection) sets when a program or erase is issued with `lock_hit_i` or `bp_hit_i` high. It also sets when a program is issued with `otp_sel_i` and `otp_locked_i` both high. In all these cases the operation does not start.
- R8: A status write with `sr_wd_i` and `wp_act_i` both high sets bit 1 and gives no `wrsr_go_o`. With either one low, `wrsr_go_o` pulses.
- R9: While bit 1 is set, every program, erase, suspend, resume and status-write command is rejected. A clear-flags command is never rejected.
- R10: A clear-flags command clears bits 5, 4, 3 and 1 and leaves bit 2 alone. A set condition in the same cycle wins over the clear.
- R11: A rejected command changes no flag bit and produces no start or write pulse.
- R12: Bit 6 follows `erase_susp_i`. Bit 5 is a sticky erase-fail flag set from `erase_fail_i`. Bit 0 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_cmd_i | input | 1 | Program command strobe |
| otp_sel_i | input | 1 | Qualifies a program as an OTP program |
| erase_cmd_i | input | 1 | Erase command strobe |
| susp_cmd_i | input | 1 | Suspend command strobe |
| resume_cmd_i | input | 1 | Resume command strobe |
| wrsr_cmd_i | input | 1 | Status-register write strobe |
| clr_cmd_i | input | 1 | Clear-flags command strobe |
| busy_i | input | 1 | Engine busy |
| op_done_i | input | 1 | Engine finished the running operation |
| vpp_ok_i | input | 1 | VPP voltage valid |
| lock_hit_i | input | 1 | Target sector locked by a lock register |
| bp_hit_i | input | 1 | Target covered by block-protect bits |
| otp_locked_i | input | 1 | OTP area locked |
| sr_wd_i | input | 1 | Status write-disable bit |
| wp_act_i | input | 1 | Write-protect pin asserted |
| prog_fail_i | input | 1 | Engine reports program failure |
| erase_fail_i | input | 1 | Engine reports erase failure |
| erase_susp_i | input | 1 | Engine reports erase suspended |
| fsr_o | output | 8 | Flag status byte |
| reject_o | output | 1 | Current command refused by a set flag |
| prog_start_o | output | 1 | Start a program operation |
| erase_start_o | output | 1 | Start an erase operation |
| wrsr_go_o | output | 1 | Apply the status write |

## Verification
The assertions check several things on every cycle. No start pulse appears while a flag guarding it is set. No status write goes through under protection. The suspend bit moves only after a suspend or resume strobe. Each sticky bit holds until a clear and wins against a same-cycle clear. Only the bench scenarios can show the rest: which status inputs raise which error bit, the VPP watch window between a start and its completion, and that a refused command leaves the whole byte untouched. These are compared against a reference model each clock, under directed and random stimulus.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int FSR_W   = 8;
  localparam int B_READY = 7;
  localparam int B_ESUSP = 6;
  localparam int B_EFAIL = 5;
  localparam int B_PFAIL = 4;
  localparam int B_VPP   = 3;
  localparam int B_PSUSP = 2;
  localparam int B_PROT  = 1;

  localparam int NUM_ERR = 4;
  localparam int E_EFAIL = 0;
  localparam int E_PFAIL = 1;
  localparam int E_VPP   = 2;
  localparam int E_PROT  = 3;

  typedef logic [NUM_ERR-1:0] err_vec_t;

  function automatic int err_pos(int idx);
    case (idx)
      E_EFAIL: return B_EFAIL;
      E_PFAIL: return B_PFAIL;
      E_VPP:   return B_VPP;
      default: return B_PROT;
    endcase
  endfunction
endpackage

// File: rtl/fsr_sticky_bit.sv
module fsr_sticky_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;   // set wins over clear
    else if (clr_i) q_o <= 1'b0;
  end

  assert_sticky_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/fsr_cmd_gate.sv
module fsr_cmd_gate
  import fsr_pkg::*;
(
  input  logic     prog_cmd_i,
  input  logic     otp_sel_i,
  input  logic     erase_cmd_i,
  input  logic     susp_cmd_i,
  input  logic     resume_cmd_i,
  input  logic     wrsr_cmd_i,
  input  logic     lock_hit_i,
  input  logic     bp_hit_i,
  input  logic     otp_locked_i,
  input  logic     sr_wd_i,
  input  logic     wp_act_i,
  input  err_vec_t err_q_i,
  output logic     reject_o,
  output logic     prog_start_o,
  output logic     erase_start_o,
  output logic     wrsr_go_o,
  output logic     susp_go_o,
  output logic     resume_go_o,
  output logic     prot_set_o
);
  logic blk_prog, blk_erase, blk_other;
  logic prog_ok, erase_ok, wrsr_ok;
  logic sect_hit, prog_hit, wrsr_hit;

  always_comb begin
    blk_other = err_q_i[E_PROT];
    blk_erase = blk_other | err_q_i[E_VPP];
    blk_prog  = blk_erase | err_q_i[E_PFAIL];

    prog_ok  = prog_cmd_i  & ~blk_prog;
    erase_ok = erase_cmd_i & ~blk_erase;
    wrsr_ok  = wrsr_cmd_i  & ~blk_other;

    sect_hit = lock_hit_i | bp_hit_i;
    prog_hit = sect_hit | (otp_sel_i & otp_locked_i);
    wrsr_hit = sr_wd_i & wp_act_i;

    reject_o = (prog_cmd_i & blk_prog) | (erase_cmd_i & blk_erase)
             | ((susp_cmd_i | resume_cmd_i | wrsr_cmd_i) & blk_other);

    prog_start_o  = prog_ok  & ~prog_hit;
    erase_start_o = erase_ok & ~sect_hit;
    wrsr_go_o     = wrsr_ok  & ~wrsr_hit;
    susp_go_o     = susp_cmd_i   & ~blk_other;
    resume_go_o   = resume_cmd_i & ~blk_other;
    prot_set_o    = (prog_ok & prog_hit) | (erase_ok & sect_hit) | (wrsr_ok & wrsr_hit);
  end
endmodule

// File: rtl/flash_flag_status.sv
module flash_flag_status
  import fsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_cmd_i,
  input  logic             otp_sel_i,
  input  logic             erase_cmd_i,
  input  logic             susp_cmd_i,
  input  logic             resume_cmd_i,
  input  logic             wrsr_cmd_i,
  input  logic             clr_cmd_i,
  input  logic             busy_i,
  input  logic             op_done_i,
  input  logic             vpp_ok_i,
  input  logic             lock_hit_i,
  input  logic             bp_hit_i,
  input  logic             otp_locked_i,
  input  logic             sr_wd_i,
  input  logic             wp_act_i,
  input  logic             prog_fail_i,
  input  logic             erase_fail_i,
  input  logic             erase_susp_i,
  output logic [FSR_W-1:0] fsr_o,
  output logic             reject_o,
  output logic             prog_start_o,
  output logic             erase_start_o,
  output logic             wrsr_go_o
);
  err_vec_t err_q, err_set;
  logic     susp_go, resume_go, prot_set, op_start;
  logic     op_q, psusp_q;

  fsr_cmd_gate u_gate (
    .prog_cmd_i    (prog_cmd_i),
    .otp_sel_i     (otp_sel_i),
    .erase_cmd_i   (erase_cmd_i),
    .susp_cmd_i    (susp_cmd_i),
    .resume_cmd_i  (resume_cmd_i),
    .wrsr_cmd_i    (wrsr_cmd_i),
    .lock_hit_i    (lock_hit_i),
    .bp_hit_i      (bp_hit_i),
    .otp_locked_i  (otp_locked_i),
    .sr_wd_i       (sr_wd_i),
    .wp_act_i      (wp_act_i),
    .err_q_i       (err_q),
    .reject_o      (reject_o),
    .prog_start_o  (prog_start_o),
    .erase_start_o (erase_start_o),
    .wrsr_go_o     (wrsr_go_o),
    .susp_go_o     (susp_go),
    .resume_go_o   (resume_go),
    .prot_set_o    (prot_set)
  );

  assign op_start = prog_start_o | erase_start_o;

  // VPP watched from start until the engine reports completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        op_q <= 1'b0;
    else if (op_start)  op_q <= 1'b1;
    else if (op_done_i) op_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        psusp_q <= 1'b0;
    else if (susp_go)   psusp_q <= 1'b1;
    else if (resume_go) psusp_q <= 1'b0;
  end

  always_comb begin
    err_set          = '0;
    err_set[E_EFAIL] = erase_fail_i;
    err_set[E_PFAIL] = prog_fail_i;
    err_set[E_VPP]   = (op_start | op_q) & ~vpp_ok_i;
    err_set[E_PROT]  = prot_set;
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    fsr_sticky_bit #(.RST_VAL(1'b0)) u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (err_set[i]),
      .clr_i  (clr_cmd_i),
      .q_o    (err_q[i])
    );
  end

  always_comb begin
    fsr_o          = '0;
    fsr_o[B_READY] = ~busy_i;
    fsr_o[B_ESUSP] = erase_susp_i;
    fsr_o[B_PSUSP] = psusp_q;
    for (int i = 0; i < NUM_ERR; i++) fsr_o[err_pos(i)] = err_q[i];
  end

  assert_prog_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> !(fsr_o[B_PFAIL] || fsr_o[B_VPP] || fsr_o[B_PROT]));
  assert_erase_guard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> !(fsr_o[B_VPP] || fsr_o[B_PROT]));
  assert_prot_guard_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsr_o[B_PROT] |-> !(wrsr_go_o || prog_start_o || erase_start_o));
  assert_wrsr_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wd_i && wp_act_i) |-> !wrsr_go_o);
  assert_susp_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fsr_o[B_PSUSP]) |-> $past(susp_cmd_i));
  assert_susp_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fsr_o[B_PSUSP]) |-> $past(resume_cmd_i));
  assert_reject_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !(prog_start_o || erase_start_o || wrsr_go_o));
endmodule

// File: tb/flash_flag_status_bench.sv
module flash_flag_status_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic prog_cmd, otp_sel, erase_cmd, susp_cmd, resume_cmd, wrsr_cmd, clr_cmd;
  logic busy, op_done, vpp_ok, lock_hit, bp_hit, otp_locked, sr_wd, wp_act;
  logic prog_fail, erase_fail, erase_susp;
  logic [7:0] fsr;
  logic reject, prog_start, erase_start, wrsr_go;

  int checks = 0, fails = 0;
  bit m_pf, m_ef, m_vpp, m_prot, m_susp, m_op;

  always #(CLK_P/2) clk = ~clk;

  flash_flag_status u_flash_flag_status (
    .clk_i(clk), .rst_ni(rst_ni),
    .prog_cmd_i(prog_cmd), .otp_sel_i(otp_sel), .erase_cmd_i(erase_cmd),
    .susp_cmd_i(susp_cmd), .resume_cmd_i(resume_cmd), .wrsr_cmd_i(wrsr_cmd),
    .clr_cmd_i(clr_cmd), .busy_i(busy), .op_done_i(op_done), .vpp_ok_i(vpp_ok),
    .lock_hit_i(lock_hit), .bp_hit_i(bp_hit), .otp_locked_i(otp_locked),
    .sr_wd_i(sr_wd), .wp_act_i(wp_act), .prog_fail_i(prog_fail),
    .erase_fail_i(erase_fail), .erase_susp_i(erase_susp),
    .fsr_o(fsr), .reject_o(reject), .prog_start_o(prog_start),
    .erase_start_o(erase_start), .wrsr_go_o(wrsr_go)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: decisions of the current cycle
  function automatic bit m_bprog();  return m_prot | m_vpp | m_pf; endfunction
  function automatic bit m_berase(); return m_prot | m_vpp;        endfunction
  function automatic bit m_ps();
    return prog_cmd & !m_bprog() & !(lock_hit | bp_hit | (otp_sel & otp_locked));
  endfunction
  function automatic bit m_es(); return erase_cmd & !m_berase() & !(lock_hit | bp_hit); endfunction
  function automatic bit m_wg(); return wrsr_cmd & !m_prot & !(sr_wd & wp_act); endfunction
  function automatic bit m_rej();
    return (prog_cmd & m_bprog()) | (erase_cmd & m_berase())
         | ((susp_cmd | resume_cmd | wrsr_cmd) & m_prot);
  endfunction
  function automatic logic [7:0] m_fsr();
    return {~busy, erase_susp, m_ef, m_pf, m_vpp, m_susp, m_prot, 1'b0};
  endfunction

  always begin
    @(negedge clk);
    #(CLK_P/4 + 1);
    if (rst_ni) begin
      logic [7:0] e;
      e = m_fsr();
      for (int b = 0; b < 8; b++)
        if (fsr[b] !== e[b]) begin
          string tag;
          case (b)
            4: tag = "R2 bit4";
            3: tag = "R4 bit3";
            2: tag = "R6 bit2";
            1: tag = "R7 bit1";
            default: tag = "R12 fsr bit";
          endcase
          check(tag, fsr, e);
        end
      check("R9 reject", reject, m_rej());
      check("R11 prog_start", prog_start, m_ps());
      check("R11 erase_start", erase_start, m_es());
      check("R8 wrsr_go", wrsr_go, m_wg());
      check("R12 fsr byte", fsr, e);
    end
    @(posedge clk);
    if (!rst_ni) begin
      {m_pf, m_ef, m_vpp, m_prot, m_susp, m_op} = '0;
    end else begin
      bit ps, es, wg, pset, vset, sg, rg, st;
      ps = m_ps(); es = m_es(); wg = m_wg();
      st = ps | es;
      pset = (prog_cmd & !m_bprog() & !ps) | (erase_cmd & !m_berase() & !es)
           | (wrsr_cmd & !m_prot & !wg);
      vset = (st | m_op) & !vpp_ok;
      sg = susp_cmd & !m_prot;
      rg = resume_cmd & !m_prot;
      m_pf   = prog_fail  | (m_pf   & !clr_cmd);
      m_ef   = erase_fail | (m_ef   & !clr_cmd);
      m_vpp  = vset       | (m_vpp  & !clr_cmd);
      m_prot = pset       | (m_prot & !clr_cmd);
      if (sg) m_susp = 1'b1; else if (rg) m_susp = 1'b0;
      if (st) m_op = 1'b1; else if (op_done) m_op = 1'b0;
    end
  end

  task automatic go();
    @(negedge clk); #1;
    {prog_cmd, otp_sel, erase_cmd, susp_cmd, resume_cmd, wrsr_cmd, clr_cmd} = '0;
    {op_done, prog_fail, erase_fail} = '0;
    {lock_hit, bp_hit} = '0;
  endtask

  task automatic look(); #2; endtask

  initial begin
    {prog_cmd, otp_sel, erase_cmd, susp_cmd, resume_cmd, wrsr_cmd, clr_cmd} = '0;
    {busy, op_done, lock_hit, bp_hit, otp_locked, sr_wd, wp_act} = '0;
    {prog_fail, erase_fail, erase_susp} = '0;
    vpp_ok = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    look(); check("R1 reset byte", fsr, 8'h80);
    busy = 1'b1; look(); check("R1 ready follows busy", fsr, 8'h00);
    busy = 1'b0;

    // R2 R3: program fail is sticky and blocks programs only
    go(); prog_cmd = 1; look(); check("R3 clean program starts", prog_start, 1);
    go(); busy = 1; prog_fail = 1;
    go(); busy = 0; op_done = 1; look(); check("R2 fail flag set", fsr[4], 1);
    go(); go(); look(); check("R2 fail flag held", fsr[4], 1);
    go(); prog_cmd = 1; look(); check("R3 program rejected", reject, 1);
    check("R3 no program start", prog_start, 0);
    go(); erase_cmd = 1; look(); check("R3 erase still accepted", erase_start, 1);
    go(); op_done = 1; clr_cmd = 1;
    go(); look(); check("R10 clear drops fail flag", fsr[4], 0);

    // R4 R5: VPP loss during operation
    go(); erase_cmd = 1;
    go(); busy = 1;
    go(); vpp_ok = 0;
    go(); vpp_ok = 1; look(); check("R4 vpp flag set mid-op", fsr[3], 1);
    go(); busy = 0; op_done = 1;
    go(); prog_cmd = 1; look(); check("R5 program rejected", reject, 1);
    go(); erase_cmd = 1; look(); check("R5 erase rejected", erase_start, 0);
    go(); wrsr_cmd = 1; look(); check("R5 status write accepted", wrsr_go, 1);
    go(); clr_cmd = 1; prog_fail = 1;
    go(); look(); check("R10 set wins over clear", fsr[4], 1);
    check("R10 vpp cleared", fsr[3], 0);
    go(); clr_cmd = 1;
    go(); vpp_ok = 0; prog_cmd = 1;
    go(); vpp_ok = 1; op_done = 1; look(); check("R4 vpp bad at start", fsr[3], 1);
    go(); clr_cmd = 1;

    // R6 suspend/resume
    go(); susp_cmd = 1;
    go(); look(); check("R6 suspend sets bit2", fsr[2], 1);
    go(); clr_cmd = 1;
    go(); look(); check("R10 clear keeps bit2", fsr[2], 1);
    go(); resume_cmd = 1;
    go(); look(); check("R6 resume clears bit2", fsr[2], 0);

    // R7 R8 R9 R11 protection
    go(); prog_cmd = 1; lock_hit = 1; look(); check("R7 locked program no start", prog_start, 0);
    go(); look(); check("R7 protection set", fsr[1], 1);
    go(); susp_cmd = 1; look(); check("R9 suspend rejected", reject, 1);
    go(); look(); check("R11 rejected suspend leaves bit2", fsr[2], 0);
    go(); wrsr_cmd = 1; look(); check("R9 status write rejected", wrsr_go, 0);
    go(); clr_cmd = 1; look(); check("R9 clear not rejected", reject, 0);
    go(); look(); check("R10 protection cleared", fsr[1], 0);
    go(); erase_cmd = 1; bp_hit = 1; look(); check("R7 protected erase no start", erase_start, 0);
    go(); clr_cmd = 1;
    go(); prog_cmd = 1; otp_sel = 1; otp_locked = 1; look(); check("R7 OTP locked", prog_start, 0);
    go(); otp_locked = 0; look(); check("R7 OTP protection", fsr[1], 1);
    clr_cmd = 1;
    go(); wrsr_cmd = 1; sr_wd = 1; wp_act = 1; look(); check("R8 locked status write", wrsr_go, 0);
    go(); look(); check("R8 protection from status write", fsr[1], 1);
    clr_cmd = 1;
    go(); wrsr_cmd = 1; wp_act = 0; look(); check("R8 unlocked status write", wrsr_go, 1);
    sr_wd = 0;

    // R12 misc bits
    go(); erase_susp = 1; look(); check("R12 erase suspend mirrors", fsr[6], 1);
    erase_fail = 1;
    go(); erase_susp = 0; look(); check("R12 erase fail sticky", fsr[5], 1);
    check("R12 bit0 zero", fsr[0], 0);
    clr_cmd = 1;

    // random traffic, model compared each cycle
    for (int n = 0; n < 400; n++) begin
      int c;
      go();
      c = $urandom_range(0, 11);
      case (c)
        0: prog_cmd = 1;
        1: begin prog_cmd = 1; otp_sel = 1; end
        2: erase_cmd = 1;
        3: susp_cmd = 1;
        4: resume_cmd = 1;
        5: wrsr_cmd = 1;
        6, 7: clr_cmd = 1;
        default: ;
      endcase
      lock_hit   = ($urandom_range(0, 5) == 0);
      bp_hit     = ($urandom_range(0, 7) == 0);
      otp_locked = $urandom_range(0, 1);
      sr_wd      = $urandom_range(0, 1);
      wp_act     = $urandom_range(0, 1);
      vpp_ok     = ($urandom_range(0, 9) != 0);
      busy       = $urandom_range(0, 1);
      op_done    = ($urandom_range(0, 3) == 0);
      prog_fail  = ($urandom_range(0, 15) == 0);
      erase_fail = ($urandom_range(0, 15) == 0);
      erase_susp = $urandom_range(0, 1);
    end
    go(); go();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule